// File: doc/BRIEF.md
# Core Thermal Threshold and Throttle Register Block

This block gives one processor core a small register file for thermal limits. Software programs a thermal configuration word that sets several values: an activation temperature, two downward offsets from it (one for the hot signal, one for the fan request), an averaging window and a clamp option. Software can then freeze the word with a lock bit. The block compares an 8-bit die temperature in degrees C against the two thresholds it derives from that word. From the comparisons it drives a hot indication and a fan request to the rest of the chip.

The block also keeps an exponential moving average of the temperature. The average advances on each pulse of a sample strobe. When the window is non-zero and the integer part of the average reaches the hot threshold, the block raises a throttle request. A second register, the limit-reason word, shows the live throttle status and a sticky log of it. Software clears the log by writing zero to the log bit. Frequency selection, fan hardware and the sensor are outside the block.

Top module: `thermal_limit_regs`

## Requirements
- R1: The configuration word at address 0 has these fields: window in bits 6:0, clamp in bit 7, fan offset in bits 15:8, activation temperature in bits 23:16, hot offset in bits 30:24 and lock in bit 31. It reads back through `reg_rdata` in the same cycle the address is presented. Bits 63:32 read as zero.
- R2: While lock (bit 31) is 1, writes to the configuration word change no field. Only reset clears the lock.
- R3: A configuration write updates bits 30:24 only when `plat_ofs_en` is 1. Otherwise those bits keep their value while the other fields still update.
- R4: One cycle after a clock edge, `hot_o` shows whether the temperature at that edge was at least the hot threshold. The hot threshold is the activation temperature minus the hot offset.
- R5: One cycle after a clock edge, `fan_o` shows whether the temperature at that edge was at least the activation temperature minus the fan offset. For example, an activation of 0x61 with a fan offset of 0x0A gives a fan threshold of 87.
- R6: Both threshold subtractions saturate at 0, so an offset larger than the activation temperature gives a threshold of 0.
- R7: On each `sample_stb` edge, the average (8 fraction bits) becomes avg + ((temp·256 − avg) >>> s), where s = min(window, 8) and the shift is arithmetic. Without a strobe the average holds. `throttle_o` is registered. It is 1 when the window is non-zero and the integer part of the average is at least the hot threshold.
- R8: The limit-reason word is at address 1. Bit 5 reads the live throttle status. Writes never change bit 5.
- R9: Bit 21 of the limit-reason word is a log that sets on any cycle in which the status is 1. A write to address 1 with bit 21 equal to 0 clears the log, unless the status is 1 in that cycle, in which case setting wins. Writing 1 to bit 21 has no effect.
- R10: `deep_o` is 1 only when the throttle request is active and the clamp bit (bit 7) is set. With the clamp bit clear, the request stays limited to the base non-turbo level and `deep_o` stays 0.
- R11: After reset, every register and every output is zero, and any address other than 0 or 1 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Register address (0 config, 1 limit reason) |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| plat_ofs_en | input | 1 | Allows writes to the hot offset field |
| temp_in | input | 8 | Die temperature, unsigned degrees C |
| sample_stb | input | 1 | Advances the moving average |
| hot_o | output | 1 | Hot indication |
| fan_o | output | 1 | Fan request |
| throttle_o | output | 1 | Throttle request from the moving average |
| deep_o | output | 1 | Throttle may go below the base frequency level |

## Verification
The assertions assume that `temp_in`, `sample_stb`, `plat_ofs_en` and the register port are stable around each clock edge. The hot-output property also assumes the registered output variant. The stimulus changes every input two nanoseconds after a rising edge. It draws temperatures, strobes, addresses (including unmapped ones) and write data from a seeded generator, and it sets the lock bit only rarely so that long unlocked stretches still occur. Resets at intervals clear the lock so that the random write traffic keeps reaching the fields.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
   localparam int TEMP_W   = 8;
   localparam int CFG_W    = 32;
   localparam int STAT_BIT = 5;
   localparam int LOG_BIT  = 21;

   typedef struct packed {
      logic       lock;
      logic [6:0] hot_ofs;
      logic [7:0] act_temp;
      logic [7:0] fan_ofs;
      logic       clamp;
      logic [6:0] window;
   } therm_cfg_t;

   function automatic logic [TEMP_W-1:0] sat_sub(input logic [TEMP_W-1:0] a,
                                                 input logic [TEMP_W-1:0] b);
      return (a > b) ? (a - b) : '0;
   endfunction
endpackage

// File: rtl/tl_cfg_reg.sv
module tl_cfg_reg
   import thermal_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CFG_W-1:0] wdata,
   input  logic             plat_en,
   output therm_cfg_t       cfg
);
   therm_cfg_t cfg_q;
   therm_cfg_t wr_cfg;

   assign wr_cfg = therm_cfg_t'(wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr && !cfg_q.lock) begin
         cfg_q.window   <= wr_cfg.window;
         cfg_q.clamp    <= wr_cfg.clamp;
         cfg_q.fan_ofs  <= wr_cfg.fan_ofs;
         cfg_q.act_temp <= wr_cfg.act_temp;
         cfg_q.lock     <= wr_cfg.lock;
         if (plat_en) begin
            cfg_q.hot_ofs <= wr_cfg.hot_ofs;
         end
      end
   end

   assign cfg = cfg_q;
endmodule

// File: rtl/tl_thresh.sv
module tl_thresh
   import thermal_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  therm_cfg_t        cfg,
   input  logic [TEMP_W-1:0] temp,
   output logic [TEMP_W-1:0] hot_thr,
   output logic              hot,
   output logic              fan
);
   logic [TEMP_W-1:0] fan_thr;
   logic              hot_raw;
   logic              fan_raw;

   assign hot_thr = sat_sub(cfg.act_temp, {1'b0, cfg.hot_ofs});
   assign fan_thr = sat_sub(cfg.act_temp, cfg.fan_ofs);
   assign hot_raw = (temp >= hot_thr);
   assign fan_raw = (temp >= fan_thr);

   generate
      if (REG_OUT) begin : g_reg
         logic hot_q, fan_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hot_q <= 1'b0;
               fan_q <= 1'b0;
            end else begin
               hot_q <= hot_raw;
               fan_q <= fan_raw;
            end
         end
         assign hot = hot_q;
         assign fan = fan_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign hot = hot_raw;
         assign fan = fan_raw;
      end
   endgenerate
endmodule

// File: rtl/tl_avg.sv
module tl_avg
   import thermal_pkg::*;
#(
   parameter int MAX_SHIFT = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        stb,
   input  logic [TEMP_W-1:0]           temp,
   input  logic [6:0]                  window,
   input  logic [TEMP_W-1:0]           target,
   output logic [TEMP_W+MAX_SHIFT-1:0] avg,
   output logic                        status
);
   localparam int AVG_W = TEMP_W + MAX_SHIFT;
   localparam int SH_W  = $clog2(MAX_SHIFT + 1);

   logic [AVG_W-1:0]        avg_q;
   logic [SH_W-1:0]         shamt;
   logic signed [AVG_W:0]   diff;
   logic signed [AVG_W:0]   step;
   logic signed [AVG_W:0]   sum;
   logic                    status_q;

   assign shamt = (window > 7'(MAX_SHIFT)) ? SH_W'(MAX_SHIFT) : window[SH_W-1:0];
   assign diff  = $signed({1'b0, temp, {MAX_SHIFT{1'b0}}}) - $signed({1'b0, avg_q});
   assign step  = diff >>> shamt;
   assign sum   = $signed({1'b0, avg_q}) + step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         avg_q    <= '0;
         status_q <= 1'b0;
      end else begin
         if (stb) begin
            avg_q <= sum[AVG_W-1:0];
         end
         status_q <= (window != '0) && (avg_q[AVG_W-1:MAX_SHIFT] >= target);
      end
   end

   assign avg    = avg_q;
   assign status = status_q;
endmodule

// File: rtl/tl_reason.sv
module tl_reason (
   input  logic clk,
   input  logic rst_n,
   input  logic status,
   input  logic clr,
   output logic log_bit
);
   logic log_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         log_q <= 1'b0;
      end else begin
         log_q <= status | (log_q & ~clr);
      end
   end

   assign log_bit = log_q;
endmodule

// File: rtl/thermal_limit_regs.sv
module thermal_limit_regs
   import thermal_pkg::*;
#(
   parameter int                ADDR_W    = 4,
   parameter int                DATA_W    = 64,
   parameter int                MAX_SHIFT = 8,
   parameter bit                REG_OUT   = 1'b1,
   parameter logic [ADDR_W-1:0] CFG_ADDR  = 'h0,
   parameter logic [ADDR_W-1:0] LIM_ADDR  = 'h1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              plat_ofs_en,
   input  logic [TEMP_W-1:0] temp_in,
   input  logic              sample_stb,
   output logic              hot_o,
   output logic              fan_o,
   output logic              throttle_o,
   output logic              deep_o
);
   localparam int AVG_W = TEMP_W + MAX_SHIFT;

   generate
      if (DATA_W <= CFG_W) begin : g_bad_data
         $error("DATA_W must exceed the configuration width");
      end
      if (MAX_SHIFT < 1 || MAX_SHIFT > 16) begin : g_bad_shift
         $error("MAX_SHIFT must lie in 1..16");
      end
      if (CFG_ADDR == LIM_ADDR) begin : g_bad_addr
         $error("register addresses must differ");
      end
   endgenerate

   therm_cfg_t        cfg_q;
   logic [TEMP_W-1:0] hot_thr;
   logic [AVG_W-1:0]  avg_val;
   logic              status;
   logic              log_q;
   logic              wr_cfg;
   logic              clr_log;
   logic              unused_hi;

   assign wr_cfg    = reg_we && (reg_addr == CFG_ADDR);
   assign clr_log   = reg_we && (reg_addr == LIM_ADDR) && !reg_wdata[LOG_BIT];
   assign unused_hi = ^reg_wdata[DATA_W-1:CFG_W];

   tl_cfg_reg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_cfg),
      .wdata   (reg_wdata[CFG_W-1:0]),
      .plat_en (plat_ofs_en),
      .cfg     (cfg_q)
   );

   tl_thresh #(.REG_OUT(REG_OUT)) u_thr (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg     (cfg_q),
      .temp    (temp_in),
      .hot_thr (hot_thr),
      .hot     (hot_o),
      .fan     (fan_o)
   );

   tl_avg #(.MAX_SHIFT(MAX_SHIFT)) u_avg (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (sample_stb),
      .temp   (temp_in),
      .window (cfg_q.window),
      .target (hot_thr),
      .avg    (avg_val),
      .status (status)
   );

   tl_reason u_rsn (
      .clk     (clk),
      .rst_n   (rst_n),
      .status  (status),
      .clr     (clr_log),
      .log_bit (log_q)
   );

   assign throttle_o = status;
   assign deep_o     = status & cfg_q.clamp;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == CFG_ADDR) begin
         reg_rdata[CFG_W-1:0] = cfg_q;
      end else if (reg_addr == LIM_ADDR) begin
         reg_rdata[STAT_BIT] = status;
         reg_rdata[LOG_BIT]  = log_q;
      end
   end
endmodule

module tl_chk #(
   parameter int AVG_W   = 16,
   parameter bit REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       temp_in,
   input logic             sample_stb,
   input logic             plat_en,
   input logic             wr_cfg,
   input logic [31:0]      cfg_bits,
   input logic             hot_o,
   input logic             throttle_o,
   input logic             log_q,
   input logic             clr,
   input logic [AVG_W-1:0] avg
);
   logic hot_due;
   assign hot_due = ({1'b0, temp_in} + {2'b0, cfg_bits[30:24]}) >= {1'b0, cfg_bits[23:16]};

   // R2
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bits[31] && wr_cfg) |=> $stable(cfg_bits));

   // R2
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_bits[31] |=> cfg_bits[31]);

   // R3
   ofs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cfg && !plat_en) |=> $stable(cfg_bits[30:24]));

   generate
      if (REG_OUT) begin : g_hot
         // R4
         hot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hot_due |=> hot_o);
         // R4
         hot_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !hot_due |=> !hot_o);
      end
   endgenerate

   // R7
   avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_stb |=> $stable(avg));

   // R9
   log_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      throttle_o |=> log_q);

   // R9
   log_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (log_q && !clr) |=> log_q);
endmodule

bind thermal_limit_regs tl_chk #(.AVG_W(AVG_W), .REG_OUT(REG_OUT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .temp_in    (temp_in),
   .sample_stb (sample_stb),
   .plat_en    (plat_ofs_en),
   .wr_cfg     (wr_cfg),
   .cfg_bits   (cfg_q),
   .hot_o      (hot_o),
   .throttle_o (throttle_o),
   .log_q      (log_q),
   .clr        (clr_log),
   .avg        (avg_val)
);

// File: tb/sim_thermal_limit_regs.sv
`timescale 1ns/1ps
module sim_thermal_limit_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        plat_ofs_en = 1'b0;
   logic [7:0]  temp_in = '0;
   logic        sample_stb = 1'b0;
   logic        hot_o, fan_o, throttle_o, deep_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   thermal_limit_regs u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .plat_ofs_en(plat_ofs_en),
      .temp_in(temp_in), .sample_stb(sample_stb), .hot_o(hot_o), .fan_o(fan_o),
      .throttle_o(throttle_o), .deep_o(deep_o)
   );

   // reference model built from the requirements
   logic [31:0] m_cfg;
   longint      m_avg;
   logic        m_stat, m_log, m_hot, m_fan;

   function automatic int sat(input int a, input int b);
      return (a > b) ? a - b : 0;
   endfunction

   function automatic int hot_thr(input logic [31:0] c);
      return sat(int'(c[23:16]), int'(c[30:24]));
   endfunction

   function automatic longint ema(input longint avg, input int t, input int win);
      int s;
      longint d;
      s = (win > 8) ? 8 : win;
      d = (longint'(t) * 256) - avg;
      return avg + (d >>> s);
   endfunction

   function automatic logic [63:0] exp_rd(input logic [3:0] a);
      logic [63:0] r;
      r = '0;
      if (a == 4'd0) r[31:0] = m_cfg;
      else if (a == 4'd1) begin
         r[5]  = m_stat;
         r[21] = m_log;
      end
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cfg <= '0; m_avg <= 0; m_stat <= 0; m_log <= 0; m_hot <= 0; m_fan <= 0;
      end else begin
         if (reg_we && reg_addr == 4'd0 && !m_cfg[31]) begin
            m_cfg[31]    <= reg_wdata[31];
            m_cfg[23:0]  <= reg_wdata[23:0];
            if (plat_ofs_en) m_cfg[30:24] <= reg_wdata[30:24];
         end
         if (sample_stb) m_avg <= ema(m_avg, int'(temp_in), int'(m_cfg[6:0]));
         m_stat <= (m_cfg[6:0] != 0) && ((m_avg >> 8) >= longint'(hot_thr(m_cfg)));
         m_log  <= m_stat | (m_log & !(reg_we && reg_addr == 4'd1 && !reg_wdata[21]));
         m_hot  <= int'(temp_in) >= hot_thr(m_cfg);
         m_fan  <= int'(temp_in) >= sat(int'(m_cfg[23:16]), int'(m_cfg[15:8]));
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R4 hot_o", {63'd0, hot_o}, {63'd0, m_hot});
      chk("R5 fan_o", {63'd0, fan_o}, {63'd0, m_fan});
      chk("R7 throttle_o", {63'd0, throttle_o}, {63'd0, m_stat});
      chk("R10 deep_o", {63'd0, deep_o}, {63'd0, m_stat & m_cfg[7]});
      chk("R1/R8 read", reg_rdata, exp_rd(reg_addr));
   endtask

   task automatic step();
      @(posedge clk);
      #2;
      compare_all();
   endtask

   task automatic wr(input logic [3:0] a, input logic [63:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      step();
      reg_we = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; reg_we = 1'b0; sample_stb = 1'b0; temp_in = '0;
      step();
      // R11 reset state
      chk("R11 outputs", {60'd0, hot_o, fan_o, throttle_o, deep_o}, 64'd0);
      reg_addr = 4'd0; #1;
      chk("R11 cfg read", reg_rdata, 64'd0);
      reg_addr = 4'd1; #1;
      chk("R11 reason read", reg_rdata, 64'd0);
      rst_n = 1'b1;
      step();
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      do_reset();
      reg_addr = 4'd7; #1;
      chk("R11 unmapped read", reg_rdata, 64'd0);

      // fan and hot thresholds
      plat_ofs_en = 1'b1;
      wr(4'd0, 64'h0000_0000_0061_0A00);
      temp_in = 8'd86; step();
      chk("R5 fan below 87", {63'd0, fan_o}, 64'd0);
      temp_in = 8'd87; step();
      chk("R5 fan at 87", {63'd0, fan_o}, 64'd1);
      temp_in = 8'd97; step();
      chk("R4 hot at 97", {63'd0, hot_o}, 64'd1);
      temp_in = 8'd96; step();
      chk("R4 hot below 97", {63'd0, hot_o}, 64'd0);
      reg_addr = 4'd0; #1;
      chk("R1 readback", reg_rdata, 64'h0000_0000_0061_0A00);

      // saturation
      wr(4'd0, 64'hFFFF_FFFF_1405_1000);
      temp_in = 8'd0; step();
      chk("R6 hot saturated", {63'd0, hot_o}, 64'd1);
      chk("R6 fan saturated", {63'd0, fan_o}, 64'd1);
      reg_addr = 4'd0; #1;
      chk("R1 upper zero", reg_rdata, 64'h0000_0000_1405_1000);

      // platform gating
      plat_ofs_en = 1'b0;
      wr(4'd0, 64'h7F61_0000);
      reg_addr = 4'd0; #1;
      chk("R3 offset kept", reg_rdata, 64'h1461_0000);
      plat_ofs_en = 1'b1;

      // lock
      wr(4'd0, 64'h8061_0A05);
      wr(4'd0, 64'h0000_0000);
      step(); step();
      reg_addr = 4'd0; #1;
      chk("R2 locked", reg_rdata, 64'h8061_0A05);
      do_reset();
      wr(4'd0, 64'h0000_0003);
      reg_addr = 4'd0; #1;
      chk("R2 unlocked by reset", reg_rdata, 64'h0000_0003);

      // throttle with clamp
      wr(4'd0, 64'h0032_0081);
      temp_in = 8'd100; sample_stb = 1'b1;
      for (int i = 0; i < 20; i++) step();
      chk("R7 throttle on", {63'd0, throttle_o}, 64'd1);
      chk("R10 deep with clamp", {63'd0, deep_o}, 64'd1);
      reg_addr = 4'd1; #1;
      chk("R8/R9 reason", reg_rdata, 64'h0020_0020);
      wr(4'd1, 64'h0000_0000);
      reg_addr = 4'd1; #1;
      chk("R9 set wins", reg_rdata, 64'h0020_0020);
      temp_in = 8'd0;
      for (int i = 0; i < 30; i++) step();
      chk("R7 throttle off", {63'd0, throttle_o}, 64'd0);
      reg_addr = 4'd1; #1;
      chk("R9 log sticky", reg_rdata, 64'h0020_0000);
      wr(4'd1, 64'h0020_0000);
      reg_addr = 4'd1; #1;
      chk("R9 write one", reg_rdata, 64'h0020_0000);
      wr(4'd1, 64'h0000_0020);
      reg_addr = 4'd1; #1;
      chk("R8 status write ignored", reg_rdata, 64'h0);

      // throttle without clamp
      wr(4'd0, 64'h0032_0001);
      temp_in = 8'd100;
      for (int i = 0; i < 20; i++) step();
      chk("R10 no deep without clamp", {62'd0, throttle_o, deep_o}, 64'h2);
      sample_stb = 1'b0;

      // random traffic
      for (int i = 0; i < 6000; i++) begin
         if (i % 1500 == 1499) do_reset();
         reg_addr    = 4'($urandom_range(0, 3));
         reg_we      = ($urandom_range(0, 3) == 0);
         reg_wdata   = {$urandom, $urandom};
         if ($urandom_range(0, 15) != 0) reg_wdata[31] = 1'b0;
         plat_ofs_en = $urandom_range(0, 1) == 1;
         temp_in     = 8'($urandom_range(0, 255));
         sample_stb  = $urandom_range(0, 1) == 1;
         step();
      end
      reg_we = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end
endmodule